// File: doc/BRIEF.md
# Total-Store-Order Write Buffer with Load Forwarding

This block sits between one hardware thread and memory, and it gives that thread total store ordering. Stores from the core do not go to memory at once. They enter a small in-order queue and drain to memory one at a time over a valid/ready write port, always oldest first.

Loads never wait in the queue. A load is answered in the cycle it is presented. The block first searches every buffered store for the load address. If any store matches, the data of the youngest matching store is returned. A store accepted in that same cycle counts as younger than anything already queued. If no store matches, the load reads memory directly through a combinational read port, even while older stores to other addresses are still queued. This is how a later load can pass an earlier store.

A fence request is held by the core, which issues no stores while it waits. The buffer reports completion once every buffered store has reached memory. The queue depth is a parameter and must be a power of two (8 by default). Addresses and data are 32 bits wide.

Top module: `tso_wbuf`

## Requirements
- R1: An accepted store (st_valid_i high while st_ready_o is high) is kept in the buffer and is not written to memory in the cycle it is accepted. The occupancy goes up by one for each accepted store and down by one for each write that memory accepts.
- R2: When the buffer holds stores, mem_wr_valid_o is high and the write port shows the oldest store. Stores reach memory strictly in the order they were accepted. The oldest entry is removed only in a cycle where mem_wr_ready_i is high. While a write is stalled, its address and data do not change.
- R3: A load (ld_valid_i high) whose address matches a buffered store returns that store's data in the same cycle, with ld_fwd_o = 1 and mem_rd_en_o = 0.
- R4: When several buffered stores match the load address, the load returns the data of the most recently accepted one.
- R5: A load that matches no buffered store and no store accepted in the same cycle raises mem_rd_en_o with mem_rd_addr_o equal to the load address. It returns mem_rd_data_i in the same cycle with ld_fwd_o = 0, even while older stores to other addresses are still queued. When no load is presented, mem_rd_en_o stays low.
- R6: A store and a load to the same address in the same cycle are ordered store first: if the store is accepted, the load returns the new store's data with ld_fwd_o = 1.
- R7: When 8 stores are buffered (the default depth), st_ready_o is low and a presented store is not accepted. The occupancy never exceeds the depth.
- R8: fence_done_o is a one-cycle pulse. It is raised in the cycle after a cycle in which fence_req_i was high, the buffer was empty and no store was accepted. A fence issued to an empty buffer therefore completes in the next cycle, and a fence never completes while stores remain buffered.
- R9: During and after reset the buffer is empty: st_ready_o = 1, mem_wr_valid_o = 0 and fence_done_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid_i | input | 1 | Store request |
| st_addr_i | input | 32 | Store address |
| st_data_i | input | 32 | Store data |
| st_ready_o | output | 1 | Buffer can accept a store |
| ld_valid_i | input | 1 | Load request, answered in the same cycle |
| ld_addr_i | input | 32 | Load address |
| ld_data_o | output | 32 | Load result |
| ld_fwd_o | output | 1 | Load was served from a buffered or incoming store |
| fence_req_i | input | 1 | Fence request, held until fence_done_o |
| fence_done_o | output | 1 | Fence completion pulse |
| mem_wr_valid_o | output | 1 | Memory write request (oldest buffered store) |
| mem_wr_addr_o | output | 32 | Memory write address |
| mem_wr_data_o | output | 32 | Memory write data |
| mem_wr_ready_i | input | 1 | Memory accepts the write this cycle |
| mem_rd_en_o | output | 1 | Memory read request for a load that missed |
| mem_rd_addr_o | output | 32 | Memory read address |
| mem_rd_data_i | input | 32 | Memory read data, combinational with the address |

## Verification
The assertions assume that the core never presents a store while it holds a fence request. They also assume that memory returns read data in the same cycle as the read address, and that stores are held low during reset. The stimulus follows these rules: every fence phase forces st_valid_i low until fence_done_o is seen, and the bench drives mem_rd_data_i from its own memory model at the same time it drives the load address. Load and store addresses are drawn from a handful of words. This makes multiple matches, same-cycle matches and misses behind pending stores frequent. The write-ready signal is toggled randomly so that both stalled and accepted writes occur.

// File: rtl/tso_wbuf_pkg.sv
package tso_wbuf_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wb_entry_t;
endpackage

// File: rtl/wbuf_queue.sv
module wbuf_queue
  import tso_wbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  wb_entry_t        push_entry_i,
  input  logic             pop_i,
  output wb_entry_t        slots_o [DEPTH],
  output logic [PTR_W-1:0] head_o,
  output logic [CNT_W-1:0] occ_o
);
  wb_entry_t        slot_q [DEPTH];
  logic [PTR_W-1:0] head_q, head_d;
  logic [PTR_W-1:0] tail_q, tail_d;
  logic [CNT_W-1:0] occ_q, occ_d;

  // next-state
  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    if (pop_i)  head_d = head_q + PTR_W'(1);
    if (push_i) tail_d = tail_q + PTR_W'(1);
    occ_d = occ_q + CNT_W'(push_i) - CNT_W'(pop_i);
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      occ_q  <= occ_d;
    end
  end

  // storage, written only under its enable
  always_ff @(posedge clk) begin
    if (push_i) slot_q[tail_q] <= push_entry_i;
  end

  assign slots_o = slot_q;
  assign head_o  = head_q;
  assign occ_o   = occ_q;
endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd
  import tso_wbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  wb_entry_t         slots_i [DEPTH],
  input  logic [PTR_W-1:0]  head_i,
  input  logic [CNT_W-1:0]  occ_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic              new_valid_i,
  input  wb_entry_t         new_entry_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  logic [PTR_W-1:0] idx;

  // Walk from oldest to youngest; a later match overrides an earlier one,
  // and the store accepted this cycle is younger than all queued entries.
  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    idx    = '0;
    for (int unsigned age = 0; age < DEPTH; age++) begin
      idx = head_i + PTR_W'(age);
      if ((CNT_W'(age) < occ_i) && (slots_i[idx].addr == ld_addr_i)) begin
        hit_o  = 1'b1;
        data_o = slots_i[idx].data;
      end
    end
    if (new_valid_i && (new_entry_i.addr == ld_addr_i)) begin
      hit_o  = 1'b1;
      data_o = new_entry_i.data;
    end
  end
endmodule

// File: rtl/wbuf_fence.sv
module wbuf_fence (
  input  logic clk,
  input  logic rst_n,
  input  logic fence_req_i,
  input  logic empty_i,
  input  logic push_i,
  output logic fence_done_o
);
  logic done_q, done_d;

  always_comb begin
    done_d = fence_req_i && empty_i && !push_i && !done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign fence_done_o = done_q;
endmodule

// File: rtl/tso_wbuf.sv
module tso_wbuf
  import tso_wbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic              st_ready_o,
  input  logic              ld_valid_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              ld_fwd_o,
  input  logic              fence_req_i,
  output logic              fence_done_o,
  output logic              mem_wr_valid_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  input  logic              mem_wr_ready_i,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic [DATA_W-1:0] mem_rd_data_i
);
  wb_entry_t        slots [DEPTH];
  wb_entry_t        new_entry;
  logic [PTR_W-1:0] head;
  logic [CNT_W-1:0] occ;
  logic             push, pop, empty;
  logic             fwd_hit;
  logic [DATA_W-1:0] fwd_data;

  assign empty      = (occ == '0);
  assign st_ready_o = (occ != CNT_W'(DEPTH));
  assign push       = st_valid_i && st_ready_o;
  assign pop        = !empty && mem_wr_ready_i;
  assign new_entry  = '{addr: st_addr_i, data: st_data_i};

  wbuf_queue #(.DEPTH(DEPTH)) queue_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push),
    .push_entry_i (new_entry),
    .pop_i        (pop),
    .slots_o      (slots),
    .head_o       (head),
    .occ_o        (occ)
  );

  wbuf_fwd #(.DEPTH(DEPTH)) fwd_i (
    .slots_i     (slots),
    .head_i      (head),
    .occ_i       (occ),
    .ld_addr_i   (ld_addr_i),
    .new_valid_i (push),
    .new_entry_i (new_entry),
    .hit_o       (fwd_hit),
    .data_o      (fwd_data)
  );

  wbuf_fence fence_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fence_req_i  (fence_req_i),
    .empty_i      (empty),
    .push_i       (push),
    .fence_done_o (fence_done_o)
  );

  assign mem_wr_valid_o = !empty;
  assign mem_wr_addr_o  = slots[head].addr;
  assign mem_wr_data_o  = slots[head].data;

  assign ld_fwd_o      = ld_valid_i && fwd_hit;
  assign mem_rd_en_o   = ld_valid_i && !fwd_hit;
  assign mem_rd_addr_o = ld_addr_i;
  assign ld_data_o     = fwd_hit ? fwd_data : mem_rd_data_i;
endmodule

// File: rtl/tso_wbuf_chk.sv
module tso_wbuf_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_valid_i,
  input logic [31:0]      st_addr_i,
  input logic [31:0]      st_data_i,
  input logic             st_ready_o,
  input logic             ld_valid_i,
  input logic [31:0]      ld_addr_i,
  input logic [31:0]      ld_data_o,
  input logic             ld_fwd_o,
  input logic             fence_req_i,
  input logic             fence_done_o,
  input logic             mem_wr_valid_o,
  input logic [31:0]      mem_wr_addr_o,
  input logic [31:0]      mem_wr_data_o,
  input logic             mem_wr_ready_i,
  input logic             mem_rd_en_o,
  input logic [31:0]      mem_rd_addr_o,
  input logic [CNT_W-1:0] occ
);
  logic acc_st, acc_wr;
  assign acc_st = st_valid_i && st_ready_o;
  assign acc_wr = mem_wr_valid_o && mem_wr_ready_i;

  // R1
  occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (int'(occ) == int'($past(occ)) + ($past(acc_st) ? 1 : 0) - ($past(acc_wr) ? 1 : 0)));

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid_o && !mem_wr_ready_i) |=>
      (mem_wr_valid_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o)));

  // R5
  rd_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_i && (occ == '0) && !acc_st) |-> (mem_rd_en_o && !ld_fwd_o && (mem_rd_addr_o == ld_addr_i)));

  // R6
  same_cycle_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_st && ld_valid_i && (st_addr_i == ld_addr_i)) |-> (ld_fwd_o && (ld_data_o == st_data_i)));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= int'(DEPTH));

  // R8
  fence_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done_o |-> ($past(occ) == '0) && $past(fence_req_i) && !$past(acc_st));

  // R8
  fence_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done_o |=> !fence_done_o);
endmodule

bind tso_wbuf tso_wbuf_chk #(.DEPTH(DEPTH)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .st_valid_i     (st_valid_i),
  .st_addr_i      (st_addr_i),
  .st_data_i      (st_data_i),
  .st_ready_o     (st_ready_o),
  .ld_valid_i     (ld_valid_i),
  .ld_addr_i      (ld_addr_i),
  .ld_data_o      (ld_data_o),
  .ld_fwd_o       (ld_fwd_o),
  .fence_req_i    (fence_req_i),
  .fence_done_o   (fence_done_o),
  .mem_wr_valid_o (mem_wr_valid_o),
  .mem_wr_addr_o  (mem_wr_addr_o),
  .mem_wr_data_o  (mem_wr_data_o),
  .mem_wr_ready_i (mem_wr_ready_i),
  .mem_rd_en_o    (mem_rd_en_o),
  .mem_rd_addr_o  (mem_rd_addr_o),
  .occ            (occ)
);

// File: tb/tso_wbuf_tb_top.sv
module tso_wbuf_tb_top;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        st_valid_i, st_ready_o;
  logic [31:0] st_addr_i, st_data_i;
  logic        ld_valid_i, ld_fwd_o;
  logic [31:0] ld_addr_i, ld_data_o;
  logic        fence_req_i, fence_done_o;
  logic        mem_wr_valid_o, mem_wr_ready_i;
  logic [31:0] mem_wr_addr_o, mem_wr_data_o;
  logic        mem_rd_en_o;
  logic [31:0] mem_rd_addr_o, mem_rd_data_i;

  tso_wbuf #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_data_i(st_data_i), .st_ready_o(st_ready_o),
    .ld_valid_i(ld_valid_i), .ld_addr_i(ld_addr_i), .ld_data_o(ld_data_o), .ld_fwd_o(ld_fwd_o),
    .fence_req_i(fence_req_i), .fence_done_o(fence_done_o),
    .mem_wr_valid_o(mem_wr_valid_o), .mem_wr_addr_o(mem_wr_addr_o), .mem_wr_data_o(mem_wr_data_o),
    .mem_wr_ready_i(mem_wr_ready_i),
    .mem_rd_en_o(mem_rd_en_o), .mem_rd_addr_o(mem_rd_addr_o), .mem_rd_data_i(mem_rd_data_i)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  logic [31:0] mem[logic [31:0]];
  logic        exp_fd = 1'b0;
  int unsigned data_seq = 32'h1000;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic drive(logic sv, logic [31:0] sa, logic lv, logic [31:0] la, logic wr, logic fr);
    st_valid_i     = sv;
    st_addr_i      = sa;
    st_data_i      = data_seq;
    data_seq       = data_seq + 1;
    ld_valid_i     = lv;
    ld_addr_i      = la;
    mem_rd_data_i  = mem_rd(la);
    mem_wr_ready_i = wr;
    fence_req_i    = fr;
  endtask

  // one clock: compare outputs late in the cycle, then advance the model at the edge
  task automatic cyc();
    logic push, pop, hit, nxt_fd;
    logic [31:0] d;
    int nm;
    string tag;
    #4;
    push = st_valid_i && (q_addr.size() < DEPTH);
    pop  = (q_addr.size() > 0) && mem_wr_ready_i;
    chk("R7 st_ready", {31'b0, st_ready_o}, {31'b0, q_addr.size() < DEPTH});
    chk("R2 wr_valid", {31'b0, mem_wr_valid_o}, {31'b0, q_addr.size() > 0});
    if (q_addr.size() > 0) begin
      chk("R2 wr_addr", mem_wr_addr_o, q_addr[0]);
      chk("R2 wr_data", mem_wr_data_o, q_data[0]);
    end
    chk("R8 fence_done", {31'b0, fence_done_o}, {31'b0, exp_fd});
    if (ld_valid_i) begin
      hit = 1'b0; nm = 0; d = mem_rd_data_i; tag = "R5";
      foreach (q_addr[i]) begin
        if (q_addr[i] == ld_addr_i) begin
          hit = 1'b1; d = q_data[i]; nm++;
        end
      end
      if (hit) tag = (nm > 1) ? "R4" : "R3";
      if (push && st_addr_i == ld_addr_i) begin
        hit = 1'b1; d = st_data_i; tag = "R6";
      end
      chk({tag, " ld_fwd"}, {31'b0, ld_fwd_o}, {31'b0, hit});
      chk({tag, " ld_data"}, ld_data_o, d);
      chk({tag, " rd_en"}, {31'b0, mem_rd_en_o}, {31'b0, !hit});
      if (!hit) chk("R5 rd_addr", mem_rd_addr_o, ld_addr_i);
    end else begin
      chk("R5 rd_en idle", {31'b0, mem_rd_en_o}, 32'h0);
    end
    nxt_fd = fence_req_i && (q_addr.size() == 0) && !push && !exp_fd;
    @(posedge clk);
    if (pop) begin
      mem[q_addr[0]] = q_data[0];
      void'(q_addr.pop_front());
      void'(q_data.pop_front());
    end
    if (push) begin
      q_addr.push_back(st_addr_i);
      q_data.push_back(st_data_i);
    end
    exp_fd = nxt_fd;
    @(negedge clk);
  endtask

  function automatic logic [31:0] raddr();
    return {26'b0, 4'($urandom % 6), 2'b00};
  endfunction

  task automatic run_fence();
    int n = 0;
    drive(1'b0, '0, 1'b0, '0, 1'($urandom), 1'b1);
    cyc();
    while (!fence_done_o && n < 200) begin
      drive(1'b0, '0, 1'($urandom), raddr(), 1'($urandom), 1'b1);
      cyc();
      n++;
    end
    chk("R8 fence completes with empty buffer", {31'b0, fence_done_o}, 32'h1);
    chk("R8 buffer drained at fence", q_addr.size(), 0);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 st_ready in reset", {31'b0, st_ready_o}, 32'h1);
    chk("R9 wr_valid in reset", {31'b0, mem_wr_valid_o}, 32'h0);
    chk("R9 fence_done in reset", {31'b0, fence_done_o}, 32'h0);
    rst_n = 1'b1;

    // R8 fence at empty completes next cycle
    drive(1'b0, '0, 1'b0, '0, 1'b0, 1'b1);
    cyc();
    chk("R8 fence on empty buffer", {31'b0, fence_done_o}, 32'h1);
    drive(1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    cyc();

    // R1 R7 fill with memory stalled, loads hitting repeated addresses (R3 R4)
    for (int i = 0; i < 11; i++) begin
      drive(1'b1, {28'b0, 2'(i % 3), 2'b00}, 1'b1, {28'b0, 2'(i % 4), 2'b00}, 1'b0, 1'b0);
      cyc();
    end
    chk("R7 full after eight stores", q_addr.size(), DEPTH);
    chk("R1 nothing reached memory while stalled", mem.num(), 0);

    // R2 drain with toggling ready
    for (int i = 0; i < 30; i++) begin
      drive(1'b0, '0, 1'b1, raddr(), 1'(i % 2), 1'b0);
      cyc();
    end
    chk("R2 buffer drained", q_addr.size(), 0);
    chk("R2 youngest write to word 0 landed last", mem_rd(32'h0), 32'h1000 + 32'd9);

    // R6 same-cycle store and load
    drive(1'b1, 32'h40, 1'b1, 32'h40, 1'b0, 1'b0);
    cyc();
    // R5 miss overtakes pending store to another address
    drive(1'b0, '0, 1'b1, 32'h4, 1'b0, 1'b0);
    cyc();
    chk("R5 pending store still queued", q_addr.size(), 1);

    // R8 fence with stores pending
    for (int i = 0; i < 3; i++) begin
      drive(1'b1, raddr(), 1'b0, '0, 1'b0, 1'b0);
      cyc();
    end
    run_fence();
    drive(1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
    cyc();

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 60 == 0) begin
        run_fence();
        drive(1'b0, '0, 1'b0, '0, 1'b0, 1'b0);
        cyc();
      end else begin
        drive(1'($urandom), raddr(), 1'($urandom), raddr(), ($urandom % 3) == 0, 1'b0);
        cyc();
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule